// File: doc/BRIEF.md
# Three-Level Pin Response Capture

This block turns the two comparator outputs of one tester pin into a single logged bit per vector. One comparator reports that the pin is at or above the high threshold. The other reports that it is at or below the low threshold. From these two flags the block classifies the pin as high, low or invalid. It then picks the bit to store, which depends on whether the channel is in plain record mode or in real-time compare mode.

A sample is taken on each vector-clock enable, but only when the step is an input step or a response-recording step. Because the driver and the receiver share the pin, the response-recording flag is how the driven data is captured. Each accepted sample leaves as a registered write to record memory: a strobe, an address and one data bit. The address advances after each write, wraps at a parameterised depth, and returns to zero on a start pulse.

Top module: `resp_capture`

## Requirements
- R1: With the high flag set and the low flag clear, the pin is classified high, and in record mode (`rtc_mode`=0) the logged bit is 1.
- R2: With the low flag set and the high flag clear, the pin is classified low, and in record mode the logged bit is 0.
- R3: With neither flag set, the pin is classified invalid, and in record mode the logged bit is 0.
- R4: With both flags set at once, the sample is treated as invalid. It logs 0 in record mode and 1 in compare mode.
- R5: In real-time compare mode (`rtc_mode`=1), a high or low sample logs 0 and an invalid sample logs 1.
- R6: A write is issued only for a cycle that has `vec_en`=1, `start`=0 and at least one of `in_step` or `resp_rec` set. `wr_en` pulses for one cycle on the clock edge after that sample cycle. In every other cycle `wr_en` is 0, and `wr_addr` and `wr_data` hold their last values.
- R7: Each write uses the address after the previous write's address, and the address after DEPTH-1 is 0.
- R8: A `start` pulse drops any sample in its own cycle, and the next write after it goes to address 0.
- R9: While and after synchronous reset `rst`, `wr_en`, `wr_addr` and `wr_data` are 0, and the first write goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_en | input | 1 | Vector clock enable, one pulse per vector |
| cmp_hi | input | 1 | Pin at or above high threshold |
| cmp_lo | input | 1 | Pin at or below low threshold |
| in_step | input | 1 | Current step is an input step |
| resp_rec | input | 1 | Current step records the driven response |
| rtc_mode | input | 1 | 1 = real-time compare logging, 0 = record logging |
| start | input | 1 | Restart capture at address 0 |
| wr_en | output | 1 | Record memory write strobe |
| wr_addr | output | $clog2(DEPTH) | Record memory write address |
| wr_data | output | 1 | Logged bit |

## Verification
The hardest conditions to reach are at the edges of the address sequence. One is the wrap from DEPTH-1 to 0. The other is a start pulse that lands on a cycle that would otherwise be sampled, with writes pending on each side of it. Directed runs of more than DEPTH consecutive writes reach the wrap. A start is raised alongside a qualifying sample, both in the middle of a run and right after the wrap. Long random stretches then mix sparse starts, gaps in the vector enable and all four flag combinations in both modes. A behavioural model is compared against the outputs on every clock.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic [1:0] {
    LVL_LOW     = 2'd0,
    LVL_HIGH    = 2'd1,
    LVL_INVALID = 2'd2
  } level_t;
endpackage

// File: rtl/rcc_classify.sv
module rcc_classify
  import rcc_pkg::*;
(
  input  logic   above_hi,
  input  logic   below_lo,
  output level_t level
);
  // Exactly one flag decides; zero or two flags are both treated as invalid.
  always_comb begin
    unique case ({above_hi, below_lo})
      2'b10:   level = LVL_HIGH;
      2'b01:   level = LVL_LOW;
      default: level = LVL_INVALID;
    endcase
  end
endmodule

// File: rtl/rcc_logsel.sv
module rcc_logsel
  import rcc_pkg::*;
(
  input  level_t level,
  input  logic   cmp_mode,
  output logic   log_bit
);
  always_comb begin
    if (cmp_mode) log_bit = (level == LVL_INVALID);
    else          log_bit = (level == LVL_HIGH);
  end
endmodule

// File: rtl/rcc_addr_ctr.sv
module rcc_addr_ctr #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)   ptr <= '0;
    else if (adv)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/resp_capture.sv
module resp_capture
  import rcc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vec_en,
  input  logic          cmp_hi,
  input  logic          cmp_lo,
  input  logic          in_step,
  input  logic          resp_rec,
  input  logic          rtc_mode,
  input  logic          start,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_data
);
  level_t        level;
  logic          log_bit;
  logic          take;
  logic [AW-1:0] ptr;

  assign take = vec_en && (in_step || resp_rec) && !start;

  rcc_classify u_cls (
    .above_hi (cmp_hi),
    .below_lo (cmp_lo),
    .level    (level)
  );

  rcc_logsel u_sel (
    .level    (level),
    .cmp_mode (rtc_mode),
    .log_bit  (log_bit)
  );

  rcc_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .adv (take),
    .ptr (ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= 1'b0;
    end else begin
      wr_en <= take;
      if (take) begin
        wr_addr <= ptr;
        wr_data <= log_bit;
      end
    end
  end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          vec_en,
  input logic          cmp_hi,
  input logic          cmp_lo,
  input logic          in_step,
  input logic          resp_rec,
  input logic          rtc_mode,
  input logic          start,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          wr_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // Set by reset or start, cleared by the next write seen at the outputs.
  logic restart_pend;
  always_ff @(posedge clk) begin
    if (rst || start) restart_pend <= 1'b1;
    else if (wr_en)   restart_pend <= 1'b0;
  end

  a_r6_write_qualified: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(vec_en && (in_step || resp_rec) && !start));

  a_r1_record_value: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(rtc_mode)) |-> (wr_data == ($past(cmp_hi) && !$past(cmp_lo))));

  a_r5_compare_value: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(rtc_mode)) |-> (wr_data == ($past(cmp_hi) == $past(cmp_lo))));

  a_r7_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |->
      (wr_addr == (($past(wr_addr) == LAST) ? '0 : $past(wr_addr) + 1'b1)));

  a_r8_start_drops: assert property (@(posedge clk) disable iff (rst)
    $past(start) |-> !wr_en);

  a_r8_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && restart_pend) |-> (wr_addr == '0));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !$past(rst)) |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

bind resp_capture rcc_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/resp_capture_tb.sv
module resp_capture_tb;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec_en = 0, cmp_hi = 0, cmp_lo = 0, in_step = 0, resp_rec = 0;
  logic rtc_mode = 0, start = 0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wr_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Reference model state.
  int    m_ptr = 0;
  bit    e_en = 0;
  int    e_addr = 0;
  bit    e_data = 0;
  string e_dtag = "R9";
  string e_atag = "R9";

  always #5 clk = ~clk;

  resp_capture #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .vec_en(vec_en), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .in_step(in_step), .resp_rec(resp_rec), .rtc_mode(rtc_mode), .start(start),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare outputs, then apply the next inputs and advance the model.
  task automatic step(input bit r, input bit v, input bit h, input bit l,
                      input bit is, input bit rr, input bit m, input bit s);
    @(negedge clk);
    chk(e_en ? "R6 strobe" : "R6 idle strobe", int'(wr_en), int'(e_en));
    chk(e_atag, int'(wr_addr), e_addr);
    chk(e_dtag, int'(wr_data), int'(e_data));
    rst = r; vec_en = v; cmp_hi = h; cmp_lo = l;
    in_step = is; resp_rec = rr; rtc_mode = m; start = s;
    if (r) begin
      m_ptr = 0; e_en = 0; e_addr = 0; e_data = 0;
      e_dtag = "R9"; e_atag = "R9";
    end else if (s) begin
      m_ptr = 0; e_en = 0; e_atag = "R8";
    end else if (v && (is || rr)) begin
      bit valid;
      valid = (h != l);
      e_en = 1;
      e_addr = m_ptr;
      m_ptr = (m_ptr + 1) % DEPTH;
      if (m) e_data = !valid;
      else   e_data = h && !l;
      if (h && l)       e_dtag = "R4";
      else if (m)       e_dtag = "R5";
      else if (h)       e_dtag = "R1";
      else if (l)       e_dtag = "R2";
      else              e_dtag = "R3";
      if (e_atag != "R8" || e_addr != 0) e_atag = "R7";
    end else begin
      e_en = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    // R9: reset state.
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 1, 0, 0, 0);
    idle(2);
    // R1 R2 R3 R4 in record mode, via input step.
    step(0, 1, 1, 0, 1, 0, 0, 0);
    step(0, 1, 0, 1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 1, 0, 0, 0);
    step(0, 1, 1, 1, 1, 0, 0, 0);
    // R5 R4 in compare mode, via response recording.
    step(0, 1, 1, 0, 0, 1, 1, 0);
    step(0, 1, 0, 1, 0, 1, 1, 0);
    step(0, 1, 0, 0, 0, 1, 1, 0);
    step(0, 1, 1, 1, 0, 1, 1, 0);
    // R6: no step qualifier, or no vector enable.
    step(0, 1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 1, 0, 0);
    idle(1);
    // R7: run through the wrap.
    for (int i = 0; i < DEPTH + 5; i++) step(0, 1, i[0], !i[0], 1, 0, i[1], 0);
    // R8: start on a qualifying sample mid-run, then resume.
    step(0, 1, 1, 0, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 1, 0, 0, 0);
    // R8: start right after a wrap.
    for (int i = 0; i < DEPTH - 4; i++) step(0, 1, 1, 0, 1, 0, 0, 0);
    step(0, 1, 0, 0, 1, 1, 0, 1);
    step(0, 1, 0, 0, 1, 1, 1, 0);
    // Random mix with sparse starts and a mid-run reset.
    for (int i = 0; i < 4000; i++) begin
      bit s;
      s = ($urandom_range(0, 40) == 0);
      step(i == 2000, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, s);
    end
    idle(2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 10);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule